// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block sits between a MAC receive byte stream and a host memory ring. Each incoming frame is written byte by byte behind a reserved 4-byte slot. When the last byte arrives, a header word carrying the status and the byte count is put into that slot. The next frame then starts on the following 4-byte boundary. Offsets wrap modulo a ring size that a 2-bit selector chooses.

The host consumes frames by walking the headers. It reports its progress through a read pointer register, which holds the consumed offset minus 16. From that register and the committed write pointer the block derives an empty flag. A frame that would run into unread data is discarded. So is a frame whose first byte arrives while a header write is still occupying the memory port. Four interrupt flags report good frames, errored frames, ring overflow and port-collision drops.

Top module: `rx_ring_writer`

## Requirements
- R1: The ring size is 2^(BASE_LOG2+k) bytes, where k is `size_sel`. Values 0, 1 and 2 give 1x, 2x and 4x the base size, and value 3 acts as 2. Every offset wraps modulo this size, and every write address stays below it.
- R2: An accepted frame gets a header word at its 4-byte-aligned start offset, written with all four byte enables. Bits 31:16 hold the byte count of the frame, FCS included. Bits 15:0 hold the header status. Byte lane i of the word is byte `offset+i` of the ring.
- R3: The header status copies input status bits 15, 14 and 13 (multicast, physical match, broadcast). It also copies bits 5..1 (bad symbol, runt, too long, CRC error, bad alignment). Bit 0 is 1 exactly when bits 5..1 are all zero, and all other bits are 0.
- R4: Byte k of a frame whose start offset is B is written at (B+4+k) mod size. The write has one byte enable, for lane address[1:0], and the byte is repeated on all four lanes.
- R5: After an accepted frame of L bytes, the write pointer becomes (B + roundup4(L+4)) mod size. `wr_ptr` is always a multiple of 4, and it is 0 after reset.
- R6: The read pointer register resets to 0xFFF0 and holds the last host-written value. The ring read offset is (register + 16) mod size.
- R7: `rx_empty` is 1 exactly when the read offset equals `wr_ptr`.
- R8: The header of a frame is presented on the write port in the cycle after the edge that samples the last byte. `wr_ptr`, `rx_empty` and interrupt bit 0 or 1 change only one edge later.
- R9: Interrupt status bit 0 flags a committed good frame and bit 1 a committed errored frame. Bits other than 0, 1, 4 and 6 read 0.
- R10: Free space is (read offset - B) mod size, with 0 counting as the full size. A frame is accepted only if roundup4(L+4) is less than the free space. Otherwise no header is written, `wr_ptr` stays put, no byte lands at or beyond the free space, and bit 4 is set one edge after the last byte.
- R11: If `in_valid` is high in the cycle right after the last byte of an accepted frame, that new frame is dropped whole and bit 6 is set one edge after its last byte.
- R12: When `ack_we` is high, interrupt bits at 1 in `ack_mask` are cleared. A bit being set in the same edge stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| size_sel | input | 2 | Ring size selector |
| in_valid | input | 1 | Receive byte valid |
| in_data | input | 8 | Receive byte |
| in_last | input | 1 | Last byte of frame |
| in_stat | input | 16 | Frame status, valid with `in_last` |
| rdp_we | input | 1 | Host write of read pointer register |
| rdp_wdata | input | 16 | Read pointer value (consumed offset minus 16) |
| rdp | output | 16 | Read pointer register |
| ack_we | input | 1 | Interrupt acknowledge strobe |
| ack_mask | input | 16 | Write-one-to-clear mask |
| isr | output | 16 | Interrupt status |
| rx_empty | output | 1 | No unread frame in the ring |
| wr_ptr | output | BASE_LOG2+2 | Committed write offset |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | BASE_LOG2+2 | Memory byte address |
| mem_be | output | 4 | Byte enables of the 32-bit word |
| mem_wdata | output | 32 | Write data |

## Verification
A data byte appears on the write port one edge after the edge that samples it. The header appears one edge after the last byte is sampled, and the committed pointer, empty flag and good/error flags follow one edge after that. Drop flags show one edge after the last byte, and read pointer writes reach the empty flag one edge after the write. Inputs are driven on falling edges. Each frame's results are read three falling edges after its last byte, when every one of these paths has settled. The directed timing test also samples the port and pointer at the intermediate falling edges to pin the header-before-commit order.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int BASE_LOG2 = 13
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             size_sel,
  input  logic                   in_valid,
  input  logic [7:0]             in_data,
  input  logic                   in_last,
  input  logic [15:0]            in_stat,
  input  logic                   rdp_we,
  input  logic [15:0]            rdp_wdata,
  output logic [15:0]            rdp,
  input  logic                   ack_we,
  input  logic [15:0]            ack_mask,
  output logic [15:0]            isr,
  output logic                   rx_empty,
  output logic [BASE_LOG2+1:0]   wr_ptr,
  output logic                   mem_we,
  output logic [BASE_LOG2+1:0]   mem_addr,
  output logic [3:0]             mem_be,
  output logic [31:0]            mem_wdata
);
  localparam int AW = BASE_LOG2 + 2;
  localparam int LEN_W = 16;
  localparam int PW = LEN_W + 1;
  localparam logic [15:0] ISR_USED = 16'h0053;

  logic [AW-1:0]    base, hdr_addr, hdr_nxt, com_off;
  logic [LEN_W-1:0] cnt;
  logic             in_frame, drop_ff, drop_sp, hdr_pend, com_pend, com_good;
  logic [31:0]      hdr_word;

  logic [1:0]    sel_eff;
  logic [AW:0]   size_b;
  logic [AW-1:0] mask, rd_off, free_raw, byte_addr, nxt_base;
  logic [PW-1:0] free_b, pos, tot;
  logic [LEN_W-1:0] len_now;
  logic [15:0]   hstat, set_v;
  logic          byte_fits, frame_fits, ff_now, sp_prev, sp_now, take, accept;

  assign sel_eff  = (size_sel == 2'd3) ? 2'd2 : size_sel;
  assign size_b   = (AW+1)'(1) << (BASE_LOG2 + int'(sel_eff));
  assign mask     = size_b[AW-1:0] - AW'(1);
  assign rd_off   = (rdp[AW-1:0] + AW'(16)) & mask;
  assign free_raw = (rd_off - base) & mask;
  assign free_b   = (free_raw == '0) ? PW'(size_b) : PW'(free_raw);

  assign pos        = PW'(cnt) + PW'(4);
  assign len_now    = cnt + LEN_W'(1);
  assign tot        = (PW'(len_now) + PW'(7)) & ~PW'(3);
  assign byte_fits  = pos < free_b;
  assign frame_fits = tot < free_b;
  assign byte_addr  = (base + pos[AW-1:0]) & mask;
  assign nxt_base   = (base + tot[AW-1:0]) & mask;
  assign hstat      = {in_stat[15:13], 7'b0, in_stat[5:1], ~|in_stat[5:1]};

  assign ff_now  = in_frame ? drop_ff : hdr_pend;
  assign sp_prev = in_frame & drop_sp;
  assign sp_now  = sp_prev | (~ff_now & ~byte_fits);
  assign take    = in_valid & ~ff_now & ~sp_prev & byte_fits;
  assign accept  = in_valid & in_last & ~ff_now & ~sp_now & frame_fits;

  assign rx_empty = (rd_off == wr_ptr);

  always_comb begin
    set_v = '0;
    if (com_pend) begin
      if (com_good) set_v[0] = 1'b1;
      else          set_v[1] = 1'b1;
    end
    if (in_valid && in_last) begin
      if (ff_now)       set_v[6] = 1'b1;
      else if (!accept) set_v[4] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0; wr_ptr <= '0; rdp <= 16'hFFF0; isr <= '0;
      cnt <= '0; in_frame <= 1'b0; drop_ff <= 1'b0; drop_sp <= 1'b0;
      hdr_pend <= 1'b0; hdr_addr <= '0; hdr_word <= '0; hdr_nxt <= '0;
      com_pend <= 1'b0; com_off <= '0; com_good <= 1'b0;
      mem_we <= 1'b0; mem_addr <= '0; mem_be <= '0; mem_wdata <= '0;
    end else begin
      if (rdp_we) rdp <= rdp_wdata;
      isr <= ((isr & ~(ack_we ? ack_mask : 16'h0)) | set_v) & ISR_USED;

      hdr_pend <= accept;
      if (accept) begin
        hdr_addr <= base;
        hdr_word <= {len_now, hstat};
        hdr_nxt  <= nxt_base;
        base     <= nxt_base;
      end

      com_pend <= hdr_pend;
      if (hdr_pend) begin
        com_off  <= hdr_nxt;
        com_good <= hdr_word[0];
      end
      if (com_pend) wr_ptr <= com_off;

      if (in_valid) begin
        if (in_last) begin
          in_frame <= 1'b0; cnt <= '0; drop_ff <= 1'b0; drop_sp <= 1'b0;
        end else begin
          in_frame <= 1'b1;
          cnt      <= (&cnt) ? cnt : cnt + LEN_W'(1);
          drop_ff  <= ff_now;
          drop_sp  <= sp_now;
        end
      end

      mem_we <= hdr_pend | take;
      if (hdr_pend) begin
        mem_addr  <= hdr_addr;
        mem_be    <= 4'hF;
        mem_wdata <= hdr_word;
      end else if (take) begin
        mem_addr  <= byte_addr;
        mem_be    <= 4'b0001 << byte_addr[1:0];
        mem_wdata <= {4{in_data}};
      end
    end
  end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int BASE_LOG2 = 13
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           size_sel,
  input logic                 rdp_we,
  input logic [15:0]          rdp,
  input logic [15:0]          isr,
  input logic                 rx_empty,
  input logic [BASE_LOG2+1:0] wr_ptr,
  input logic                 mem_we,
  input logic [BASE_LOG2+1:0] mem_addr,
  input logic [3:0]           mem_be
);
  localparam int AW = BASE_LOG2 + 2;
  logic [AW:0] lim;
  assign lim = (AW+1)'(1) << (BASE_LOG2 + ((size_sel == 2'd0) ? 0 : (size_sel == 2'd1) ? 1 : 2));

  p_addr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ({1'b0, mem_addr} < lim));
  p_hdr_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be == 4'hF) |-> (mem_addr[1:0] == 2'b00));
  p_byte_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1));
  p_ptr_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr[1:0] == 2'b00);
  p_rdp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rdp_we |=> $stable(rdp));
  p_ptr_after_hdr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_ptr) |-> $past(mem_we && mem_be == 4'hF));
  p_empty_after_hdr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rx_empty) && !$past(rdp_we)) |-> $past(mem_we && mem_be == 4'hF));
  p_isr_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (isr & 16'hFFAC) == 16'h0000);
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.BASE_LOG2(BASE_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .rdp_we(rdp_we), .rdp(rdp),
  .isr(isr), .rx_empty(rx_empty), .wr_ptr(wr_ptr), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_be(mem_be)
);

// File: tb/tb_rx_ring_writer.sv
module tb_rx_ring_writer;
  localparam int CLK_PERIOD = 10;
  localparam int BL = 6;
  localparam int AW = BL + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] size_sel = 2'd0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic [15:0] in_stat = '0;
  logic rdp_we = 1'b0, ack_we = 1'b0;
  logic [15:0] rdp_wdata = '0, ack_mask = '0;
  logic [15:0] rdp, isr;
  logic rx_empty, mem_we;
  logic [AW-1:0] wr_ptr, mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata;

  rx_ring_writer #(.BASE_LOG2(BL)) dut (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_stat(in_stat), .rdp_we(rdp_we),
    .rdp_wdata(rdp_wdata), .rdp(rdp), .ack_we(ack_we), .ack_mask(ack_mask),
    .isr(isr), .rx_empty(rx_empty), .wr_ptr(wr_ptr), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] bmem [0:(1<<AW)-1];
  always @(posedge clk)
    if (mem_we)
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) bmem[{mem_addr[AW-1:2], 2'(i)}] <= mem_wdata[8*i +: 8];

  int nchk = 0, nfail = 0;
  int m_wr, m_size;
  logic [15:0] m_rdp, m_isr;

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nfail++;
    $display("FAIL R8 watchdog: got timeout expected completion");
    report();
  end

  task automatic check(string req, string what, int got, int exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(int seed, int k);
    return 8'((seed * 37 + k * 13 + 5) & 255);
  endfunction

  function automatic logic [15:0] exp_hstat(logic [15:0] s);
    logic [15:0] r;
    r = '0;
    r[15:13] = s[15:13];
    r[5:1] = s[5:1];
    r[0] = (s[5:1] == 5'd0);
    return r;
  endfunction

  function automatic int tot_of(int len);
    return (len + 7) & ~3;
  endfunction

  function automatic int rd_of();
    return (int'(m_rdp) + 16) & (m_size - 1);
  endfunction

  function automatic bit fits(int len);
    int fr;
    fr = (rd_of() - m_wr) & (m_size - 1);
    if (fr == 0) fr = m_size;
    return tot_of(len) < fr;
  endfunction

  task automatic do_reset(logic [1:0] sel);
    @(negedge clk);
    rst_n = 1'b0; size_sel = sel; in_valid = 0; in_last = 0; rdp_we = 0; ack_we = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_size = 1 << (BL + ((sel == 2'd3) ? 2 : int'(sel)));
    m_wr = 0; m_rdp = 16'hFFF0; m_isr = 0;
  endtask

  task automatic set_rdp(logic [15:0] v);
    @(negedge clk); rdp_we = 1'b1; rdp_wdata = v;
    @(negedge clk); rdp_we = 1'b0;
    m_rdp = v;
  endtask

  task automatic consume();
    set_rdp(16'(m_wr - 16));
  endtask

  task automatic ack(logic [15:0] m);
    @(negedge clk); ack_we = 1'b1; ack_mask = m;
    @(negedge clk); ack_we = 1'b0;
    m_isr = m_isr & ~m;
  endtask

  task automatic drive_frame(int len, logic [15:0] st, int seed);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = byte_of(seed, k); in_last = (k == len - 1); in_stat = st;
    end
  endtask

  task automatic finish_frame();
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_frame(string req, int len, logic [15:0] st, int seed, int at);
    logic [31:0] h;
    int errs;
    h = {bmem[at+3], bmem[at+2], bmem[at+1], bmem[at]};
    check({req, " R2"}, "header length", int'(h[31:16]), len);
    check({req, " R3"}, "header status", int'(h[15:0]), int'(exp_hstat(st)));
    errs = 0;
    for (int k = 0; k < len; k++)
      if (bmem[(at + 4 + k) & (m_size - 1)] !== byte_of(seed, k)) errs++;
    check({req, " R4"}, "data byte mismatches", errs, 0);
  endtask

  task automatic check_state(string req);
    check({req, " R5"}, "wr_ptr", int'(wr_ptr), m_wr);
    check({req, " R9 R10"}, "isr", int'(isr), int'(m_isr));
    check({req, " R7"}, "rx_empty", int'(rx_empty), int'(rd_of() == m_wr));
  endtask

  task automatic send(string req, int len, logic [15:0] st, int seed);
    bit acc;
    int at;
    acc = fits(len);
    at = m_wr;
    drive_frame(len, st, seed);
    finish_frame();
    if (acc) begin
      check_frame(req, len, st, seed, at);
      m_wr = (m_wr + tot_of(len)) & (m_size - 1);
      m_isr = m_isr | ((st[5:1] == 5'd0) ? 16'h0001 : 16'h0002);
    end else begin
      m_isr = m_isr | 16'h0010;
    end
    check_state(req);
  endtask

  initial begin
    int at;
    void'($urandom(32'd20240611));

    do_reset(2'd0);
    @(negedge clk);
    check("R6", "reset rdp", int'(rdp), 16'hFFF0);
    check("R7", "reset rx_empty", int'(rx_empty), 1);
    check("R5", "reset wr_ptr", int'(wr_ptr), 0);
    check("R9", "reset isr", int'(isr), 0);
    check("R8", "reset mem_we", int'(mem_we), 0);

    set_rdp(16'h0000);
    check("R6", "rdp readback", int'(rdp), 0);
    check("R7", "rx_empty with rd=16 wr=0", int'(rx_empty), 0);
    set_rdp(16'hFFF0);
    check("R7", "rx_empty with rd=0 wr=0", int'(rx_empty), 1);

    // R8 header order and commit timing
    drive_frame(10, 16'h0000, 1);
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    check("R4", "last byte enable", int'(mem_be), 4'b0010);
    check("R4", "last byte address", int'(mem_addr), 13);
    check("R8", "wr_ptr before header", int'(wr_ptr), 0);
    @(negedge clk);
    check("R8", "header on port", int'({mem_we, mem_be}), 5'h1F);
    check("R8", "header address", int'(mem_addr), 0);
    check("R8", "empty still set during header", int'(rx_empty), 1);
    check("R8", "isr before commit", int'(isr), 0);
    @(negedge clk);
    check("R8", "wr_ptr after commit", int'(wr_ptr), 16);
    check("R8", "rx_empty after commit", int'(rx_empty), 0);
    check("R9", "good frame flag", int'(isr), 1);
    m_wr = 16; m_isr = 16'h0001;
    check_frame("R8", 10, 16'h0000, 1, 0);
    ack(16'hFFFF);
    check("R12", "isr after ack", int'(isr), 0);

    // R10 boundary: 56 bytes fit an empty 64-byte ring, 59 do not
    do_reset(2'd0);
    send("R10 fit", 56, 16'h4001, 2);
    check("R10", "accepted at boundary", int'(wr_ptr), 60);
    consume();
    send("R10 nofit", 59, 16'h0000, 3);
    check("R10", "dropped at boundary", int'(isr) & 16'h0010, 16'h0010);

    // R10 unread data stays intact
    do_reset(2'd0);
    send("R10 first", 20, 16'h2000, 4);
    send("R10 overrun", 40, 16'h0000, 5);
    check_frame("R10 intact", 20, 16'h2000, 4, 0);

    // R12 set wins over clear in the same edge
    consume();
    drive_frame(8, 16'h0000, 6);
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk); ack_we = 1'b1; ack_mask = 16'h0011;
    @(negedge clk); ack_we = 1'b0;
    check("R12", "set wins, bit4 cleared", int'(isr), 16'h0001);
    m_wr = (m_wr + 12) & (m_size - 1); m_isr = 16'h0001;
    check_state("R12");
    ack(16'hFFFF);

    // R11 frame starting right after an accepted last byte
    consume();
    at = m_wr;
    drive_frame(8, 16'h0000, 7);
    drive_frame(5, 16'h0000, 8);
    finish_frame();
    check_frame("R11", 8, 16'h0000, 7, at);
    m_wr = (m_wr + 12) & (m_size - 1);
    m_isr = 16'h0041;
    check_state("R11");
    check("R11", "collision flag", int'(isr), 16'h0041);
    ack(16'hFFFF);
    consume();
    send("R11 recovery", 6, 16'h0000, 9);

    // R3 errored frames
    consume();
    send("R3 err", 12, 16'hE00C, 10);
    check("R9", "error frame flag", int'(isr) & 16'h0002, 16'h0002);
    consume();
    send("R3 all", 9, 16'hFFFF, 11);

    // R1 size selection
    do_reset(2'd3);
    for (int i = 0; i < 3; i++) begin consume(); send("R1 sel3", 40, 16'h0000, 20 + i); end
    check("R1", "sel 3 acts as 256 bytes", int'(wr_ptr), 132);
    do_reset(2'd0);
    for (int i = 0; i < 2; i++) begin consume(); send("R1 sel0", 40, 16'h0000, 30 + i); end
    check("R1", "sel 0 wraps at 64 bytes", int'(wr_ptr), 24);

    // random traffic over three sizes
    for (int s = 0; s < 3; s++) begin
      do_reset(2'(s));
      for (int n = 0; n < 60; n++) begin
        if ($urandom % 4 != 0) consume();
        send("RND", 1 + int'($urandom % 40), 16'($urandom), 100 + n + s * 60);
        if ($urandom % 3 == 0) begin
          ack(16'hFFFF);
          check("R12", "isr cleared", int'(isr), 0);
        end
      end
    end

    report();
  end
endmodule